// File: doc/BRIEF.md
# Watchdog Timer with Lockable Mode Register

This block is a watchdog timer whose mode register can be written only during a short window after each reset or recovery event. The window is counted in system clock cycles. Once it has elapsed, the register holds its value and every later write is dropped. The register sets four things:

- the timeout length;
- whether counting goes on while the CPU is halted;
- whether counting goes on in stop mode;
- whether the counter advances on an RC-oscillator tick enable or on every system clock.

There is no read path, so the register is write-only.

Software arms the watchdog with its first refresh, and each later refresh clears the count. If the count reaches the selected limit, the block issues a one-cycle request. Outside stop mode this is a full reset request, and the mode register returns to its default. In stop mode it is a stop-recovery request that leaves the configuration intact. A permanent-enable strap forces the watchdog to count from reset, without any refresh, in both run and halt modes. A two-bit reset-source output records the cause of the most recent reset or recovery.

Top module: `wdt_lockcfg`

## Requirements
- R1: Writes to the mode register take effect only while fewer than WIN_CYCLES (60) clock edges have passed since the last restart. Restart events are reset release, any timeout and a `stop_recover_i` pulse. After the window has closed, writes are ignored.
- R2: Mode register layout on `cfg_wdata_i`:
  - bits [1:0]: tap;
  - bit 2: count in halt (1 = on);
  - bit 3: count in stop (1 = on);
  - bit 4: count source (0 = `rc_tick_i`, 1 = every system clock);
  - bits 7:5: ignored.

  The default is tap 01, halt counting on, stop counting off, RC source.
- R3: The tap codes select the timeout length: 00 = 128, 01 = 256, 10 = 512, 11 = 2048 qualifying ticks after a refresh. The request output is high in the cycle after the last tick.
- R4: A high `refresh_i` clears the count and arms the watchdog. With the strap low, nothing is counted before the first refresh.
- R5: While `halt_i` is high and `stop_i` is low, ticks count only if the halt bit is 1 or the strap is high.
- R6: While `stop_i` is high, ticks count only if the stop bit is 1 and the RC source is selected. On the system clock source the count holds.
- R7: With `perm_en_i` high, the watchdog counts from reset without a refresh, in run and halt modes, whatever the halt bit holds.
- R8: A timeout with `stop_i` low has these effects:
  - `wdt_rst_o` pulses for exactly one cycle;
  - `rst_src_o` becomes 01;
  - the mode register returns to its default;
  - the watchdog is disarmed.
- R9: A timeout with `stop_i` high pulses `stop_rec_o` for one cycle and sets `rst_src_o` to 10. The mode register and the armed state are kept. The two request outputs are never high together.
- R10: A `stop_recover_i` pulse, when no timeout fires at the same edge, sets `rst_src_o` to 11 and reopens the write window. The mode register is kept.
- R11: While `rst_ni` is low, both request outputs are 0 and `rst_src_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rc_tick_i | input | 1 | One-cycle tick enable from the RC oscillator domain |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 8 | Mode register write data |
| refresh_i | input | 1 | Watchdog refresh strobe |
| halt_i | input | 1 | CPU is in halt mode |
| stop_i | input | 1 | CPU is in stop mode |
| perm_en_i | input | 1 | Permanent-enable strap |
| stop_recover_i | input | 1 | External stop-mode recovery event |
| wdt_rst_o | output | 1 | One-cycle full reset request |
| stop_rec_o | output | 1 | One-cycle stop-recovery request |
| rst_src_o | output | 2 | Last cause: 00 power-on, 01 watchdog, 10 watchdog in stop, 11 stop recovery |

## Verification
The assertions assume the following about the inputs:
- `rc_tick_i` is already synchronous to `clk_i` and lasts at most a cycle per event.
- `perm_en_i` behaves as a strap, changing seldom and never mid-pulse.
- The checks on `stop_i` hold only when no refresh arrives in the same cycle.

The stimulus drives every input at the falling edge. It toggles the halt, stop and strap inputs only on rare random draws, so that each mode lasts long enough for timeouts to fall inside it. Directed sequences run on the system clock source, so that each timeout lands on a known cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef struct packed {
    logic       src_sys;
    logic       stop_en;
    logic       halt_en;
    logic [1:0] tap;
  } wdt_mode_t;

  typedef enum logic [1:0] {
    SRC_POR      = 2'b00,
    SRC_WDT      = 2'b01,
    SRC_STOP_WDT = 2'b10,
    SRC_STOP_REC = 2'b11
  } rst_src_e;

  localparam wdt_mode_t MODE_DEFAULT = '{src_sys: 1'b0, stop_en: 1'b0,
                                         halt_en: 1'b1, tap: 2'b01};

  function automatic wdt_mode_t decode_mode(input logic [7:0] d);
    wdt_mode_t m;
    m.tap     = d[1:0];
    m.halt_en = d[2];
    m.stop_en = d[3];
    m.src_sys = d[4];
    return m;
  endfunction

endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 60,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              reload_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output wdt_mode_t         mode_o,
  output logic              open_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] win_q;
  wdt_mode_t        mode_q;

  assign open_o = (win_q < WIN_LAST);
  assign mode_o = mode_q;

  // window saturates at WIN_CYCLES
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        win_q <= '0;
    else if (restart_i) win_q <= '0;
    else if (open_o)    win_q <= win_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mode_q <= MODE_DEFAULT;
    else if (reload_i)        mode_q <= MODE_DEFAULT;
    else if (we_i && open_o)  mode_q <= decode_mode(wdata_i[7:0]);
  end

endmodule

// File: rtl/wdt_gate.sv
module wdt_gate
  import wdt_pkg::*;
(
  input  wdt_mode_t mode_i,
  input  logic      rc_tick_i,
  input  logic      halt_i,
  input  logic      stop_i,
  input  logic      perm_i,
  input  logic      armed_i,
  output logic      count_en_o
);
  logic tick, mode_ok;

  assign tick = mode_i.src_sys | rc_tick_i;

  always_comb begin
    if (stop_i)      mode_ok = mode_i.stop_en & ~mode_i.src_sys;
    else if (halt_i) mode_ok = mode_i.halt_en | perm_i;
    else             mode_ok = 1'b1;
  end

  assign count_en_o = (armed_i | perm_i) & mode_ok & tick;

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TAP0 = 128,
  parameter int unsigned TAP1 = 256,
  parameter int unsigned TAP2 = 512,
  parameter int unsigned TAP3 = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] tap_i,
  output logic       fire_o
);
  localparam int unsigned MAX01 = (TAP0 > TAP1) ? TAP0 : TAP1;
  localparam int unsigned MAX23 = (TAP2 > TAP3) ? TAP2 : TAP3;
  localparam int unsigned MAXT  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CNT_W = $clog2(MAXT);

  logic [CNT_W-1:0] cnt_q, last;

  always_comb begin
    unique case (tap_i)
      2'b00:   last = CNT_W'(TAP0 - 1);
      2'b01:   last = CNT_W'(TAP1 - 1);
      2'b10:   last = CNT_W'(TAP2 - 1);
      default: last = CNT_W'(TAP3 - 1);
    endcase
  end

  // >= covers a shorter tap written while counting
  assign fire_o = en_i & ~clr_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || fire_o) cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/wdt_lockcfg.sv
module wdt_lockcfg
  import wdt_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 60,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TAP0       = 128,
  parameter int unsigned TAP1       = 256,
  parameter int unsigned TAP2       = 512,
  parameter int unsigned TAP3       = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rc_tick_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              refresh_i,
  input  logic              halt_i,
  input  logic              stop_i,
  input  logic              perm_en_i,
  input  logic              stop_recover_i,
  output logic              wdt_rst_o,
  output logic              stop_rec_o,
  output logic [1:0]        rst_src_o
);
  wdt_mode_t mode;
  logic      win_open, count_en, fire, fire_full, fire_stop, restart;
  logic      armed_q, rst_q, srec_q;
  rst_src_e  src_q;

  assign fire_full = fire & ~stop_i;
  assign fire_stop = fire & stop_i;
  assign restart   = fire | stop_recover_i;

  wdt_cfg_lock #(.WIN_CYCLES(WIN_CYCLES), .DATA_W(DATA_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .reload_i (fire_full),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .mode_o   (mode),
    .open_o   (win_open)
  );

  wdt_gate u_gate (
    .mode_i    (mode),
    .rc_tick_i (rc_tick_i),
    .halt_i    (halt_i),
    .stop_i    (stop_i),
    .perm_i    (perm_en_i),
    .armed_i   (armed_q),
    .count_en_o(count_en)
  );

  wdt_counter #(.TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (refresh_i),
    .en_i  (count_en),
    .tap_i (mode.tap),
    .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (fire_full) armed_q <= 1'b0;
    else if (refresh_i) armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      srec_q <= 1'b0;
      src_q  <= SRC_POR;
    end else begin
      rst_q  <= fire_full;
      srec_q <= fire_stop;
      if (fire_full)           src_q <= SRC_WDT;
      else if (fire_stop)      src_q <= SRC_STOP_WDT;
      else if (stop_recover_i) src_q <= SRC_STOP_REC;
    end
  end

  assign wdt_rst_o  = rst_q;
  assign stop_rec_o = srec_q;
  assign rst_src_o  = src_q;

endmodule

// File: rtl/wdt_lockcfg_chk.sv
module wdt_lockcfg_chk
  import wdt_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       refresh_i,
  input logic       stop_i,
  input logic       stop_recover_i,
  input logic       wdt_rst_o,
  input logic       stop_rec_o,
  input logic [1:0] rst_src_o,
  input wdt_mode_t  mode,
  input logic       win_open,
  input logic       fire,
  input logic       count_en
);
  // R8
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  // R9
  srec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_rec_o |=> !stop_rec_o);
  // R9
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && stop_rec_o));
  // R8
  src_wdt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> rst_src_o == SRC_WDT);
  // R9
  src_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_rec_o |-> rst_src_o == SRC_STOP_WDT);
  // R10
  src_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_recover_i && !fire) |=> rst_src_o == SRC_STOP_REC);
  // R1
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_open && !(fire && !stop_i)) |=> $stable(mode));
  // R6
  stop_sys_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && mode.src_sys) |-> !count_en);
  // R4
  refresh_nofire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> !(wdt_rst_o || stop_rec_o));
endmodule

bind wdt_lockcfg wdt_lockcfg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .refresh_i     (refresh_i),
  .stop_i        (stop_i),
  .stop_recover_i(stop_recover_i),
  .wdt_rst_o     (wdt_rst_o),
  .stop_rec_o    (stop_rec_o),
  .rst_src_o     (rst_src_o),
  .mode          (mode),
  .win_open      (win_open),
  .fire          (fire),
  .count_en      (count_en)
);

// File: tb/wdt_lockcfg_bench.sv
`timescale 1ns/1ps
module wdt_lockcfg_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rc_tick = 1'b0, we = 1'b0, refresh = 1'b0, halt = 1'b0;
  logic       stop = 1'b0, perm = 1'b0, srec_in = 1'b0;
  logic [7:0] wdata = '0;
  logic       wdt_rst, stop_rec;
  logic [1:0] rst_src;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  wdt_lockcfg u_wdt_lockcfg (
    .clk_i(clk), .rst_ni(rst_ni), .rc_tick_i(rc_tick), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .refresh_i(refresh), .halt_i(halt), .stop_i(stop),
    .perm_en_i(perm), .stop_recover_i(srec_in), .wdt_rst_o(wdt_rst),
    .stop_rec_o(stop_rec), .rst_src_o(rst_src)
  );

  // reference model state
  logic [1:0] m_tap = 2'b01;
  logic       m_halt = 1'b1, m_stop = 1'b0, m_sys = 1'b0, m_armed = 1'b0;
  int         m_win = 0, m_cnt = 0;
  logic       m_rst = 1'b0, m_srec = 1'b0;
  logic [1:0] m_src = 2'b00;

  function automatic int tap_len(input logic [1:0] t);
    case (t)
      2'b00: return 128;
      2'b01: return 256;
      2'b10: return 512;
      default: return 2048;
    endcase
  endfunction

  function automatic logic mode_allows(input logic st, input logic hl, input logic pm,
                                       input logic hen, input logic sen, input logic sys);
    if (st) return sen && !sys;
    if (hl) return hen || pm;
    return 1'b1;
  endfunction

  task automatic model_reset();
    m_tap = 2'b01; m_halt = 1'b1; m_stop = 1'b0; m_sys = 1'b0; m_armed = 1'b0;
    m_win = 0; m_cnt = 0; m_rst = 1'b0; m_srec = 1'b0; m_src = 2'b00;
  endtask

  task automatic model_step();
    logic act, fire, full, sf, open;
    if (!rst_ni) begin model_reset(); return; end
    act  = (m_armed || perm) && mode_allows(stop, halt, perm, m_halt, m_stop, m_sys)
           && (m_sys || rc_tick) && !refresh;
    fire = act && (m_cnt >= tap_len(m_tap) - 1);
    full = fire && !stop;
    sf   = fire && stop;
    open = m_win < 60;
    m_cnt = (refresh || fire) ? 0 : (act ? m_cnt + 1 : m_cnt);
    if (full) m_armed = 1'b0; else if (refresh) m_armed = 1'b1;
    if (fire || srec_in) m_win = 0; else if (open) m_win = m_win + 1;
    if (full) begin
      m_tap = 2'b01; m_halt = 1'b1; m_stop = 1'b0; m_sys = 1'b0;
    end else if (we && open) begin
      m_tap = wdata[1:0]; m_halt = wdata[2]; m_stop = wdata[3]; m_sys = wdata[4];
    end
    if (full) m_src = 2'b01; else if (sf) m_src = 2'b10; else if (srec_in) m_src = 2'b11;
    m_rst = full; m_srec = sf;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: predict next edge, wait, compare
  task automatic cyc();
    model_step();
    @(negedge clk);
    check({wdt_rst, stop_rec, rst_src} == {m_rst, m_srec, m_src}, cur_req,
          {wdt_rst, stop_rec, rst_src}, {m_rst, m_srec, m_src});
  endtask

  task automatic wait_pulse(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      cyc();
      if (wdt_rst || stop_rec) begin n = i; return; end
    end
  endtask

  task automatic write_mode(input logic [7:0] d);
    we = 1'b1; wdata = d; cyc(); we = 1'b0;
  endtask

  task automatic do_refresh();
    refresh = 1'b1; cyc(); refresh = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cyc(); rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n;
    @(negedge clk);
    // R11 reset state
    check(!wdt_rst && !stop_rec && rst_src == 2'b00, "R11", {wdt_rst, stop_rec, rst_src}, 0);
    cyc(); cyc();
    rst_ni = 1'b1;

    // R2 R3: tap 00, sysclk, halt on -> 128
    cur_req = "R3";
    write_mode(8'h14);
    do_refresh();
    wait_pulse(400, n);
    check(n == 128, "R3 tap00 length", n, 128);
    check(rst_src == 2'b01 && wdt_rst, "R8 source watchdog", rst_src, 1);

    // R1 lock: late write ignored, default RC tap01 applies (R8)
    cur_req = "R1";
    for (int i = 0; i < 70; i++) cyc();
    write_mode(8'h13);
    do_refresh();
    rc_tick = 1'b0;
    wait_pulse(300, n);
    check(n == 0, "R1 no count on idle RC source", n, 0);
    rc_tick = 1'b1;
    wait_pulse(400, n);
    check(n == 256, "R1 R8 default tap kept after lock", n, 256);
    rc_tick = 1'b0;

    // R4: not armed before refresh
    cur_req = "R4";
    write_mode(8'h10);
    wait_pulse(300, n);
    check(n == 0, "R4 idle before refresh", n, 0);
    do_reset();
    cyc();

    // R5 halt gating
    cur_req = "R5";
    write_mode(8'h10);
    halt = 1'b1;
    do_refresh();
    wait_pulse(200, n);
    check(n == 0, "R5 halt blocks count", n, 0);
    halt = 1'b0;
    wait_pulse(300, n);
    check(n == 128, "R5 resume after halt", n, 128);

    // R6 stop on sysclk holds
    cur_req = "R6";
    write_mode(8'h18);
    do_refresh();
    stop = 1'b1;
    wait_pulse(300, n);
    check(n == 0, "R6 sysclk source halts in stop", n, 0);
    stop = 1'b0;

    // R10 stop recovery reopens window
    cur_req = "R10";
    srec_in = 1'b1; cyc(); srec_in = 1'b0;
    check(rst_src == 2'b11, "R10 source stop recovery", rst_src, 3);
    write_mode(8'h08);
    do_refresh();

    // R9 timeout in stop on RC
    cur_req = "R9";
    stop = 1'b1; rc_tick = 1'b1;
    wait_pulse(300, n);
    check(n == 128 && stop_rec && !wdt_rst, "R9 stop timeout request", n, 128);
    check(rst_src == 2'b10, "R9 source stop watchdog", rst_src, 2);
    stop = 1'b0;
    do_refresh();
    wait_pulse(300, n);
    check(n == 128 && wdt_rst, "R9 mode kept after stop timeout", n, 128);
    rc_tick = 1'b0;

    // R7 permanent strap
    cur_req = "R7";
    perm = 1'b1; halt = 1'b1; rc_tick = 1'b1;
    rst_ni = 1'b0; cyc();
    rst_ni = 1'b1; we = 1'b1; wdata = 8'h01;
    wait_pulse(400, n);
    we = 1'b0;
    check(n == 256, "R7 strap counts in halt without refresh", n, 256);
    perm = 1'b0; halt = 1'b0; rc_tick = 1'b0;

    // random phase, model compared every cycle
    cur_req = "R1/R2/R3/R4/R5/R6/R8/R9/R10";
    void'($urandom(32'h5eed_1234));
    do_reset();
    for (int i = 0; i < 40000; i++) begin
      rc_tick = ($urandom % 3) == 0;
      we      = ($urandom % 6) == 0;
      wdata   = 8'($urandom);
      refresh = ($urandom % 450) == 0;
      srec_in = ($urandom % 2500) == 0;
      if (($urandom % 300) == 0)   halt = ~halt;
      if (($urandom % 700) == 0)   stop = ~stop;
      if (($urandom % 6000) == 0)  perm = ~perm;
      if (($urandom % 9000) == 0) rst_ni = 1'b0; else rst_ni = 1'b1;
      cyc();
    end
    summary();
  end
endmodule